// File: doc/BRIEF.md
# Flash Chunk Syndrome Corrector

This block checks up to four 512-byte chunks of a flash page. For each chunk it compares two 24-bit parity codes. One is the code kept with the data on the medium and the other is the code computed again from the data just read. The two codes are XOR-ed into a syndrome, and the number of set bits in the syndrome decides the outcome. An empty syndrome means the chunk is clean. A weight of exactly twelve means one data bit has flipped, and the odd-parity half of the syndrome then gives that bit's byte offset and bit index. Any other weight is reported as a failure, except for the pattern left by an erased page.

When a chunk has a single-bit error, the block repairs it in place through a read-modify-write port into a local chunk buffer. It reads the byte, inverts the bit and writes the byte back to the same address. Each chunk it visits produces a one-cycle report strobe. A run ends with a one-cycle done pulse that carries the overall verdict.

A client loads all the codes, gives a chunk count and pulses start. It then waits for done, while the buffer sits on the read-modify-write port.

Top module: `ecc_chunk_corrector`

## Requirements
- R1: Each 24-bit code holds the even-parity check for position bit k in bit k and the odd-parity check for position bit k in bit 12+k, for k = 0..11. The position is byte_offset*8 + bit_index. The syndrome is the XOR of the stored and computed codes. A syndrome of weight 0 reports the chunk as OK (chunk_status 0) and makes no buffer access.
- R2: A syndrome of weight exactly 12 reports the chunk as CORRECTED (chunk_status 1). err_byte is syndrome bits [23:15] and err_bit is syndrome bits [14:12].
- R3: For a CORRECTED chunk the block asserts buf_rd_en for one cycle at address chunk*512 + err_byte. Read data returns one cycle later. Two cycles after the read, the block asserts buf_wr_en once at the same address, with the byte that was read and bit err_bit inverted. The block makes no other writes.
- R4: A syndrome weight of 1 or 11 reports the chunk as FAILED (chunk_status 2).
- R5: Every other non-zero weight other than 12 is FAILED, with one exception. If the stored code is 24'hFFFFFF and the computed code is 24'h000000, the chunk is OK and the buffer is not touched.
- R6: Chunks are visited in order 0, 1, 2, and so on. Each visited chunk produces one chunk_valid strobe with its chunk_index. The run stops at the first FAILED chunk, and later chunks are neither reported nor repaired.
- R7: Each run ends with exactly one done pulse, during which busy is low. final_status is FAILED if the run stopped, CORRECTED if any chunk was repaired, and OK otherwise. After reset, busy, done, chunk_valid, buf_rd_en and buf_wr_en are all low.
- R8: A chunk_count of 0 gives done with OK and no chunk strobes. A count above 4 is treated as 4.
- R9: The verdict is registered. The first chunk strobe appears in the second cycle after the cycle in which start is sampled, and clean chunks report on consecutive cycles.
- R10: The codes and the count are captured when start is accepted. Changing them, or pulsing start again while busy, has no effect on the run in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (accepted only when idle) |
| chunk_count | input | 3 | Number of chunks to check, clamped to 4 |
| stored_codes | input | 96 | Stored codes, chunk c in bits [24c+23:24c] |
| calc_codes | input | 96 | Computed codes, same packing |
| busy | output | 1 | A run is in progress |
| chunk_valid | output | 1 | One-cycle report for one chunk |
| chunk_index | output | 2 | Chunk being reported |
| chunk_status | output | 2 | 0 OK, 1 CORRECTED, 2 FAILED |
| err_byte | output | 9 | Byte offset of the flipped bit (valid when CORRECTED) |
| err_bit | output | 3 | Bit index of the flipped bit (valid when CORRECTED) |
| done | output | 1 | One-cycle end-of-run pulse |
| final_status | output | 2 | Overall verdict, encoded like chunk_status |
| buf_rd_en | output | 1 | Buffer read request |
| buf_addr | output | 11 | Buffer byte address for both read and write |
| buf_rd_data | input | 8 | Buffer read data, one cycle after buf_rd_en |
| buf_wr_en | output | 1 | Buffer write strobe |
| buf_wr_data | output | 8 | Repaired byte |

## Verification
The assertions check the repair protocol on every cycle. A write must sit two cycles after a read at the same address and must differ from the fetched byte in exactly one bit. Reads and writes never overlap. A flagged chunk opens its read at the address it reports, and a failing chunk always closes the run. The bench scenarios cover what depends on the code values. They sweep every one of the 4096 error positions across all four chunks and every syndrome weight from 0 to 24. They also cover the erased-page exemption and its mirror image, stopping on a failure, count clamping, and start being ignored while busy.

// File: rtl/ecc_fix_pkg.sv
package ecc_fix_pkg;

    parameter int unsigned CHUNK_BYTES = 512;
    parameter int unsigned BYTE_W      = 8;

    localparam int unsigned BIT_W     = $clog2(BYTE_W);
    localparam int unsigned OFS_W     = $clog2(CHUNK_BYTES);
    localparam int unsigned POS_W     = OFS_W + BIT_W;
    localparam int unsigned CODE_W    = 2 * POS_W;
    localparam int unsigned SYN_CNT_W = $clog2(CODE_W + 1);

    typedef enum logic [1:0] {
        ECC_OK    = 2'd0,
        ECC_FIXED = 2'd1,
        ECC_FAIL  = 2'd2
    } ecc_status_e;

    typedef struct packed {
        ecc_status_e            status;
        logic [OFS_W-1:0]       ofs;
        logic [BIT_W-1:0]       bit_idx;
    } ecc_verdict_t;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_EVAL = 2'd1,
        SQ_FIX  = 2'd2
    } seq_state_e;

    typedef enum logic [1:0] {
        RMW_IDLE = 2'd0,
        RMW_READ = 2'd1,
        RMW_MOD  = 2'd2
    } rmw_state_e;

    // Number of set bits in a syndrome.
    function automatic logic [SYN_CNT_W-1:0] ones_in(input logic [CODE_W-1:0] v);
        logic [SYN_CNT_W-1:0] c;
        c = '0;
        for (int i = 0; i < CODE_W; i++) begin
            c = c + SYN_CNT_W'(v[i]);
        end
        return c;
    endfunction

endpackage

// File: rtl/ecc_syndrome_eval.sv
// Combinational syndrome weight and classification for one chunk.
module ecc_syndrome_eval
    import ecc_fix_pkg::*;
(
    input  logic [CODE_W-1:0] stored_i,
    input  logic [CODE_W-1:0] calc_i,
    output ecc_verdict_t      verdict_o
);

    logic [CODE_W-1:0]    syn;
    logic [SYN_CNT_W-1:0] weight;
    logic [POS_W-1:0]     odd_pos;
    logic                 erased;

    assign syn    = stored_i ^ calc_i;
    assign weight = ones_in(syn);
    assign erased = (&stored_i) && (calc_i == '0);

    // Odd-parity half of the syndrome spells the failing position.
    for (genvar k = 0; k < POS_W; k++) begin : g_odd
        assign odd_pos[k] = syn[POS_W + k];
    end

    always_comb begin
        verdict_o.ofs     = odd_pos[POS_W-1:BIT_W];
        verdict_o.bit_idx = odd_pos[BIT_W-1:0];
        if (weight == '0) begin
            verdict_o.status = ECC_OK;
        end else if (weight == SYN_CNT_W'(POS_W)) begin
            verdict_o.status = ECC_FIXED;
        end else if (erased) begin
            verdict_o.status = ECC_OK;
        end else begin
            verdict_o.status = ECC_FAIL;
        end
    end

endmodule

// File: rtl/ecc_rmw_unit.sv
// Read, invert one bit, write back: one byte per request.
module ecc_rmw_unit
    import ecc_fix_pkg::*;
#(
    parameter int unsigned ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BIT_W-1:0]  bit_i,
    input  logic [BYTE_W-1:0] rd_data_i,
    output logic              ack_o,
    output logic              rd_en_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              wr_en_o,
    output logic [BYTE_W-1:0] wr_data_o
);

    rmw_state_e        state_q;
    logic [BYTE_W-1:0] mask_q;

    assign ack_o = (state_q == RMW_MOD);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= RMW_IDLE;
            mask_q    <= '0;
            addr_o    <= '0;
            rd_en_o   <= 1'b0;
            wr_en_o   <= 1'b0;
            wr_data_o <= '0;
        end else begin
            rd_en_o <= 1'b0;
            wr_en_o <= 1'b0;
            case (state_q)
                RMW_IDLE: begin
                    if (req_i) begin
                        addr_o  <= addr_i;
                        mask_q  <= BYTE_W'(1) << bit_i;
                        rd_en_o <= 1'b1;
                        state_q <= RMW_READ;
                    end
                end
                RMW_READ: begin
                    state_q <= RMW_MOD;
                end
                RMW_MOD: begin
                    wr_en_o   <= 1'b1;
                    wr_data_o <= rd_data_i ^ mask_q;
                    state_q   <= RMW_IDLE;
                end
                default: state_q <= RMW_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/ecc_chunk_seq.sv
// Walks the chunks, registers each verdict and the overall result.
module ecc_chunk_seq
    import ecc_fix_pkg::*;
#(
    parameter int unsigned MAX_CHUNKS = 4,
    parameter int unsigned IDX_W      = 2,
    parameter int unsigned CNT_W      = 3
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         start_i,
    input  logic [CNT_W-1:0]             count_i,
    input  logic [MAX_CHUNKS*CODE_W-1:0] stored_i,
    input  logic [MAX_CHUNKS*CODE_W-1:0] calc_i,
    input  ecc_verdict_t                 verdict_i,
    input  logic                         fix_ack_i,
    output logic [CODE_W-1:0]            cur_stored_o,
    output logic [CODE_W-1:0]            cur_calc_o,
    output logic [IDX_W-1:0]             idx_o,
    output logic                         fix_req_o,
    output logic                         busy_o,
    output logic                         chunk_valid_o,
    output logic [IDX_W-1:0]             chunk_idx_o,
    output ecc_status_e                  chunk_status_o,
    output logic [OFS_W-1:0]             err_byte_o,
    output logic [BIT_W-1:0]             err_bit_o,
    output logic                         done_o,
    output ecc_status_e                  final_o
);

    seq_state_e        state_q;
    logic [IDX_W-1:0]  idx_q;
    logic [CNT_W-1:0]  n_q;
    logic [CNT_W-1:0]  n_clamped;
    logic              any_fix_q;
    logic              last;
    logic [CODE_W-1:0] lane_st [MAX_CHUNKS];
    logic [CODE_W-1:0] lane_ca [MAX_CHUNKS];
    logic [CODE_W-1:0] st_q    [MAX_CHUNKS];
    logic [CODE_W-1:0] ca_q    [MAX_CHUNKS];

    for (genvar c = 0; c < MAX_CHUNKS; c++) begin : g_lane
        assign lane_st[c] = stored_i[c*CODE_W +: CODE_W];
        assign lane_ca[c] = calc_i[c*CODE_W +: CODE_W];
    end

    assign n_clamped    = (count_i > CNT_W'(MAX_CHUNKS)) ? CNT_W'(MAX_CHUNKS) : count_i;
    assign last         = (int'(idx_q) + 1 >= int'(n_q));
    assign cur_stored_o = st_q[idx_q];
    assign cur_calc_o   = ca_q[idx_q];
    assign idx_o        = idx_q;
    assign busy_o       = (state_q != SQ_IDLE);
    assign fix_req_o    = (state_q == SQ_EVAL) && (verdict_i.status == ECC_FIXED);

    // Code capture: data registers, loaded only when a run is accepted.
    always_ff @(posedge clk) begin
        if (state_q == SQ_IDLE && start_i) begin
            for (int c = 0; c < MAX_CHUNKS; c++) begin
                st_q[c] <= lane_st[c];
                ca_q[c] <= lane_ca[c];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q        <= SQ_IDLE;
            idx_q          <= '0;
            n_q            <= '0;
            any_fix_q      <= 1'b0;
            chunk_valid_o  <= 1'b0;
            chunk_idx_o    <= '0;
            chunk_status_o <= ECC_OK;
            err_byte_o     <= '0;
            err_bit_o      <= '0;
            done_o         <= 1'b0;
            final_o        <= ECC_OK;
        end else begin
            chunk_valid_o <= 1'b0;
            done_o        <= 1'b0;
            case (state_q)
                SQ_IDLE: begin
                    if (start_i) begin
                        idx_q     <= '0;
                        any_fix_q <= 1'b0;
                        n_q       <= n_clamped;
                        if (n_clamped == '0) begin
                            done_o  <= 1'b1;
                            final_o <= ECC_OK;
                        end else begin
                            state_q <= SQ_EVAL;
                        end
                    end
                end
                SQ_EVAL: begin
                    chunk_valid_o  <= 1'b1;
                    chunk_idx_o    <= idx_q;
                    chunk_status_o <= verdict_i.status;
                    err_byte_o     <= verdict_i.ofs;
                    err_bit_o      <= verdict_i.bit_idx;
                    if (verdict_i.status == ECC_FAIL) begin
                        done_o  <= 1'b1;
                        final_o <= ECC_FAIL;
                        state_q <= SQ_IDLE;
                    end else if (verdict_i.status == ECC_FIXED) begin
                        any_fix_q <= 1'b1;
                        state_q   <= SQ_FIX;
                    end else if (last) begin
                        done_o  <= 1'b1;
                        final_o <= any_fix_q ? ECC_FIXED : ECC_OK;
                        state_q <= SQ_IDLE;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                SQ_FIX: begin
                    if (fix_ack_i) begin
                        if (last) begin
                            done_o  <= 1'b1;
                            final_o <= ECC_FIXED;
                            state_q <= SQ_IDLE;
                        end else begin
                            idx_q   <= idx_q + 1'b1;
                            state_q <= SQ_EVAL;
                        end
                    end
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/ecc_chunk_corrector.sv
module ecc_chunk_corrector
    import ecc_fix_pkg::*;
#(
    parameter int unsigned MAX_CHUNKS = 4,
    localparam int unsigned IDX_W  = (MAX_CHUNKS > 1) ? $clog2(MAX_CHUNKS) : 1,
    localparam int unsigned CNT_W  = $clog2(MAX_CHUNKS + 1),
    localparam int unsigned ADDR_W = IDX_W + OFS_W
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         start,
    input  logic [CNT_W-1:0]             chunk_count,
    input  logic [MAX_CHUNKS*CODE_W-1:0] stored_codes,
    input  logic [MAX_CHUNKS*CODE_W-1:0] calc_codes,
    output logic                         busy,
    output logic                         chunk_valid,
    output logic [IDX_W-1:0]             chunk_index,
    output logic [1:0]                   chunk_status,
    output logic [OFS_W-1:0]             err_byte,
    output logic [BIT_W-1:0]             err_bit,
    output logic                         done,
    output logic [1:0]                   final_status,
    output logic                         buf_rd_en,
    output logic [ADDR_W-1:0]            buf_addr,
    input  logic [BYTE_W-1:0]            buf_rd_data,
    output logic                         buf_wr_en,
    output logic [BYTE_W-1:0]            buf_wr_data
);

    logic [CODE_W-1:0] cur_st;
    logic [CODE_W-1:0] cur_ca;
    logic [IDX_W-1:0]  cur_idx;
    ecc_verdict_t      verdict;
    logic              fix_req;
    logic              fix_ack;
    ecc_status_e       chunk_st_e;
    ecc_status_e       final_st_e;

    assign chunk_status = chunk_st_e;
    assign final_status = final_st_e;

    ecc_chunk_seq #(
        .MAX_CHUNKS (MAX_CHUNKS),
        .IDX_W      (IDX_W),
        .CNT_W      (CNT_W)
    ) seq_i (
        .clk            (clk),
        .rst            (rst),
        .start_i        (start),
        .count_i        (chunk_count),
        .stored_i       (stored_codes),
        .calc_i         (calc_codes),
        .verdict_i      (verdict),
        .fix_ack_i      (fix_ack),
        .cur_stored_o   (cur_st),
        .cur_calc_o     (cur_ca),
        .idx_o          (cur_idx),
        .fix_req_o      (fix_req),
        .busy_o         (busy),
        .chunk_valid_o  (chunk_valid),
        .chunk_idx_o    (chunk_index),
        .chunk_status_o (chunk_st_e),
        .err_byte_o     (err_byte),
        .err_bit_o      (err_bit),
        .done_o         (done),
        .final_o        (final_st_e)
    );

    ecc_syndrome_eval eval_i (
        .stored_i  (cur_st),
        .calc_i    (cur_ca),
        .verdict_o (verdict)
    );

    ecc_rmw_unit #(
        .ADDR_W (ADDR_W)
    ) rmw_i (
        .clk       (clk),
        .rst       (rst),
        .req_i     (fix_req),
        .addr_i    ({cur_idx, verdict.ofs}),
        .bit_i     (verdict.bit_idx),
        .rd_data_i (buf_rd_data),
        .ack_o     (fix_ack),
        .rd_en_o   (buf_rd_en),
        .addr_o    (buf_addr),
        .wr_en_o   (buf_wr_en),
        .wr_data_o (buf_wr_data)
    );

endmodule

// File: rtl/ecc_chunk_corrector_chk.sv
module ecc_chunk_corrector_chk
    import ecc_fix_pkg::*;
#(
    parameter int unsigned MAX_CHUNKS = 4,
    localparam int unsigned IDX_W  = (MAX_CHUNKS > 1) ? $clog2(MAX_CHUNKS) : 1,
    localparam int unsigned ADDR_W = IDX_W + OFS_W
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              chunk_valid,
    input logic [IDX_W-1:0]  chunk_index,
    input logic [1:0]        chunk_status,
    input logic [OFS_W-1:0]  err_byte,
    input logic              done,
    input logic [1:0]        final_status,
    input logic              buf_rd_en,
    input logic [ADDR_W-1:0] buf_addr,
    input logic [BYTE_W-1:0] buf_rd_data,
    input logic              buf_wr_en,
    input logic [BYTE_W-1:0] buf_wr_data
);

    a_r3_write_follows_read: assert property (@(posedge clk) disable iff (rst)
        buf_wr_en |-> ($past(buf_rd_en, 2) && buf_addr == $past(buf_addr, 2)));

    a_r3_single_bit_flip: assert property (@(posedge clk) disable iff (rst)
        buf_wr_en |-> ($countones(buf_wr_data ^ $past(buf_rd_data)) == 1));

    a_r3_no_overlap: assert property (@(posedge clk) disable iff (rst)
        !(buf_rd_en && buf_wr_en));

    a_r3_read_at_flagged: assert property (@(posedge clk) disable iff (rst)
        (chunk_valid && chunk_status == 2'(ECC_FIXED))
            |-> (buf_rd_en && buf_addr == {chunk_index, err_byte}));

    a_r1_clean_no_access: assert property (@(posedge clk) disable iff (rst)
        (chunk_valid && chunk_status == 2'(ECC_OK)) |-> !buf_rd_en);

    a_r6_fail_ends_run: assert property (@(posedge clk) disable iff (rst)
        (chunk_valid && chunk_status == 2'(ECC_FAIL))
            |-> (done && final_status == 2'(ECC_FAIL)));

    a_r7_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && final_status != 2'd3));

    a_r2_status_legal: assert property (@(posedge clk) disable iff (rst)
        chunk_valid |-> (chunk_status != 2'd3));

endmodule

bind ecc_chunk_corrector ecc_chunk_corrector_chk #(.MAX_CHUNKS(MAX_CHUNKS)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .busy         (busy),
    .chunk_valid  (chunk_valid),
    .chunk_index  (chunk_index),
    .chunk_status (chunk_status),
    .err_byte     (err_byte),
    .done         (done),
    .final_status (final_status),
    .buf_rd_en    (buf_rd_en),
    .buf_addr     (buf_addr),
    .buf_rd_data  (buf_rd_data),
    .buf_wr_en    (buf_wr_en),
    .buf_wr_data  (buf_wr_data)
);

// File: tb/ecc_chunk_corrector_tb_top.sv
`timescale 1ns/1ps
module ecc_chunk_corrector_tb_top;
    import ecc_fix_pkg::*;

    localparam int NCH    = 4;
    localparam int IDX_W  = 2;
    localparam int CNT_W  = 3;
    localparam int ADDR_W = IDX_W + OFS_W;
    localparam int MEMSZ  = NCH * CHUNK_BYTES;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic                    rst = 1'b1;
    logic                    start = 1'b0;
    logic [CNT_W-1:0]        chunk_count = '0;
    logic [NCH*CODE_W-1:0]   stored_codes = '0;
    logic [NCH*CODE_W-1:0]   calc_codes = '0;
    logic                    busy, chunk_valid, done, buf_rd_en, buf_wr_en;
    logic [IDX_W-1:0]        chunk_index;
    logic [1:0]              chunk_status, final_status;
    logic [OFS_W-1:0]        err_byte;
    logic [BIT_W-1:0]        err_bit;
    logic [ADDR_W-1:0]       buf_addr;
    logic [BYTE_W-1:0]       buf_rd_data, buf_wr_data;

    ecc_chunk_corrector #(.MAX_CHUNKS(NCH)) dut_i (
        .clk(clk), .rst(rst), .start(start), .chunk_count(chunk_count),
        .stored_codes(stored_codes), .calc_codes(calc_codes),
        .busy(busy), .chunk_valid(chunk_valid), .chunk_index(chunk_index),
        .chunk_status(chunk_status), .err_byte(err_byte), .err_bit(err_bit),
        .done(done), .final_status(final_status), .buf_rd_en(buf_rd_en),
        .buf_addr(buf_addr), .buf_rd_data(buf_rd_data), .buf_wr_en(buf_wr_en),
        .buf_wr_data(buf_wr_data)
    );

    int n_checks = 0;
    int n_fail   = 0;

    function automatic logic [7:0] init_byte(input int a);
        return 8'((a * 37 + 11) & 255);
    endfunction

    // Local chunk buffer: synchronous read, one-cycle latency; logs writes.
    logic [7:0]        mem    [MEMSZ];
    logic [7:0]        golden [MEMSZ];
    logic [ADDR_W-1:0] wlog_a [8];
    logic [7:0]        wlog_d [8];
    int                wcount = 0;

    always @(posedge clk) begin
        if (rst) begin
            for (int a = 0; a < MEMSZ; a++) mem[a] <= init_byte(a);
            buf_rd_data <= '0;
        end else begin
            if (buf_rd_en) buf_rd_data <= mem[buf_addr];
            if (buf_wr_en) begin
                mem[buf_addr]       <= buf_wr_data;
                wlog_a[wcount % 8]  <= buf_addr;
                wlog_d[wcount % 8]  <= buf_wr_data;
                wcount              <= wcount + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Syndrome for a single flipped bit at position p (R1 layout).
    function automatic logic [23:0] one_bit_syn(input int p);
        logic [23:0] s;
        s = '0;
        for (int k = 0; k < 12; k++) begin
            if (p[k]) s[12 + k] = 1'b1;
            else      s[k]      = 1'b1;
        end
        return s;
    endfunction

    function automatic logic [1:0] exp_status(input logic [23:0] s, input logic [23:0] c);
        int w;
        w = $countones(s ^ c);
        if (w == 0) return 2'd0;
        if (w == 12) return 2'd1;
        if (s == 24'hFFFFFF && c == 24'h0) return 2'd0;
        return 2'd2;
    endfunction

    logic [23:0] cs_st [NCH];
    logic [23:0] cs_ca [NCH];

    task automatic run_case(input string tag, input int n, input bit reissue);
        logic [1:0] e_st [NCH];
        int         e_addr [NCH];
        logic [7:0] e_mask [NCH];
        int         e_byte [NCH];
        int         e_bit  [NCH];
        logic [1:0] exp_fin;
        int         exp_n, nw, eff, got, dn, extra, wbase;
        bit         all_ok;
        logic [1:0] g_st  [8];
        int         g_idx [8];
        int         g_byte[8];
        int         g_bit [8];
        int         g_t   [8];
        logic [1:0] fin;
        logic       busy_d;
        logic [23:0] syn;

        exp_n = 0; nw = 0; exp_fin = 2'd0; all_ok = 1'b1;
        eff = (n > NCH) ? NCH : n;
        for (int i = 0; i < eff; i++) begin
            syn       = cs_st[i] ^ cs_ca[i];
            e_st[i]   = exp_status(cs_st[i], cs_ca[i]);
            e_byte[i] = int'(syn[23:15]);
            e_bit[i]  = int'(syn[14:12]);
            exp_n++;
            if (e_st[i] != 2'd0) all_ok = 1'b0;
            if (e_st[i] == 2'd1) begin
                exp_fin    = 2'd1;
                e_addr[nw] = i * CHUNK_BYTES + e_byte[i];
                e_mask[nw] = 8'(1 << e_bit[i]);
                nw++;
            end
            if (e_st[i] == 2'd2) begin
                exp_fin = 2'd2;
                break;
            end
        end

        @(negedge clk);
        for (int c = 0; c < NCH; c++) begin
            stored_codes[c*24 +: 24] = cs_st[c];
            calc_codes[c*24 +: 24]   = cs_ca[c];
        end
        chunk_count = CNT_W'(n);
        start = 1'b1;
        wbase = wcount;
        got = 0; dn = 0; extra = 0; fin = 2'd0; busy_d = 1'b0;
        for (int t = 1; t <= 60 && extra < 3; t++) begin
            @(negedge clk);
            if (t == 1) begin
                if (reissue) begin
                    stored_codes = '0;
                    calc_codes   = '1;
                    chunk_count  = CNT_W'(1);
                end else begin
                    start = 1'b0;
                end
            end
            if (t == 2) start = 1'b0;
            if (chunk_valid) begin
                if (got < 8) begin
                    g_st[got]   = chunk_status;
                    g_idx[got]  = int'(chunk_index);
                    g_byte[got] = int'(err_byte);
                    g_bit[got]  = int'(err_bit);
                    g_t[got]    = t;
                end
                got++;
            end
            if (done) begin
                dn++;
                fin    = final_status;
                busy_d = busy;
            end
            if (dn > 0) extra++;
        end

        chk(dn == 1, "R7", {tag, " done pulses"}, dn, 1);
        chk(fin == exp_fin, "R7", {tag, " final status"}, fin, exp_fin);
        chk(busy_d == 1'b0, "R7", {tag, " busy at done"}, busy_d, 0);
        chk(got == exp_n, "R6", {tag, " chunk strobes"}, got, exp_n);
        for (int i = 0; i < exp_n && i < got && i < 8; i++) begin
            chk(g_idx[i] == i, "R6", {tag, " chunk order"}, g_idx[i], i);
            chk(g_st[i] == e_st[i], tag, "chunk status", g_st[i], e_st[i]);
            if (e_st[i] == 2'd1) begin
                chk(g_byte[i] == e_byte[i], "R2", {tag, " err byte"}, g_byte[i], e_byte[i]);
                chk(g_bit[i] == e_bit[i], "R2", {tag, " err bit"}, g_bit[i], e_bit[i]);
            end
        end
        if (got > 0)
            chk(g_t[0] == 2, "R9", {tag, " first strobe cycle"}, g_t[0], 2);
        if (all_ok) begin
            for (int i = 1; i < got && i < 8; i++)
                chk(g_t[i] == g_t[i-1] + 1, "R9", {tag, " clean chunk spacing"}, g_t[i], g_t[i-1] + 1);
        end
        chk(wcount - wbase == nw, "R3", {tag, " write count"}, wcount - wbase, nw);
        for (int w = 0; w < nw && w < wcount - wbase; w++) begin
            int slot;
            logic [7:0] want;
            slot = (wbase + w) % 8;
            want = golden[e_addr[w]] ^ e_mask[w];
            chk(int'(wlog_a[slot]) == e_addr[w], "R3", {tag, " write address"}, wlog_a[slot], e_addr[w]);
            chk(wlog_d[slot] == want, "R3", {tag, " write data"}, wlog_d[slot], want);
            golden[e_addr[w]] = want;
            chk(mem[e_addr[w]] == want, "R3", {tag, " buffer byte"}, mem[e_addr[w]], want);
        end
    endtask

    task automatic all_clean();
        for (int c = 0; c < NCH; c++) begin
            cs_st[c] = 24'($urandom);
            cs_ca[c] = cs_st[c];
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        for (int a = 0; a < MEMSZ; a++) golden[a] = init_byte(a);
        repeat (5) @(negedge clk);
        chk(!busy && !done && !chunk_valid && !buf_rd_en && !buf_wr_en, "R7",
            "reset state", {busy, done, chunk_valid, buf_rd_en, buf_wr_en}, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // R1: all clean, four chunks, no buffer access.
        all_clean();
        run_case("R1", 4, 1'b0);

        // R2/R3: every error position, rotating through the four chunks.
        for (int p = 0; p < 4096; p++) begin
            all_clean();
            cs_ca[p % NCH] = cs_st[p % NCH] ^ one_bit_syn(p);
            run_case("R2", 4, 1'b0);
        end

        // R4/R5: every syndrome weight on a single chunk.
        for (int w = 0; w <= 24; w++) begin
            logic [23:0] s;
            all_clean();
            s = (w == 24) ? 24'hFFFFFF : 24'((1 << w) - 1);
            s = (s << (w % 5)) | (s >> (24 - (w % 5)));
            cs_ca[0] = cs_st[0] ^ s;
            run_case((w == 1 || w == 11) ? "R4" : "R5", 1, 1'b0);
        end

        // R5: erased-page exemption, its mirror, and a near miss.
        all_clean();
        cs_st[0] = 24'hFFFFFF; cs_ca[0] = 24'h000000;
        run_case("R5", 1, 1'b0);
        all_clean();
        cs_st[0] = 24'h000000; cs_ca[0] = 24'hFFFFFF;
        run_case("R5", 1, 1'b0);
        all_clean();
        cs_st[0] = 24'hFFFFFF; cs_ca[0] = 24'h000001;
        run_case("R5", 1, 1'b0);

        // R6: mix, then stop at first failure before a repairable chunk.
        all_clean();
        cs_ca[1] = cs_st[1] ^ one_bit_syn(1234);
        cs_st[2] = 24'hFFFFFF; cs_ca[2] = 24'h0;
        cs_ca[3] = cs_st[3] ^ one_bit_syn(4095);
        run_case("R6", 4, 1'b0);
        all_clean();
        cs_ca[1] = cs_st[1] ^ 24'h000400;
        cs_ca[3] = cs_st[3] ^ one_bit_syn(77);
        run_case("R6", 4, 1'b0);

        // R8: zero count and clamped count.
        all_clean();
        run_case("R8", 0, 1'b0);
        all_clean();
        cs_ca[3] = cs_st[3] ^ one_bit_syn(9);
        run_case("R8", 7, 1'b0);

        // R10: inputs changed and start pulsed again while busy.
        all_clean();
        cs_ca[2] = cs_st[2] ^ one_bit_syn(2000);
        run_case("R10", 4, 1'b1);

        finish_run();
    end

endmodule